// File: doc/BRIEF.md
# Hot-Plug Slot Register Controller

This block holds the slot capability, slot control and slot status words of a downstream port that supports hot-plug, and produces the hot-plug interrupt. Software writes 16-bit control or status words through a single write strobe with a per-byte enable. The current words are always visible on read-data outputs. Hardware reports attention-button presses and device arrival as one-cycle pulses. At reset, a level input gives the initial presence state.

The block counts every control write as one command and flags it as completed. Status event bits clear when software writes one to them. If a status write tries to clear an event that was not yet set, the whole write is dropped, so events that arrive during the write are not lost. Writing the interlock control bit toggles the interlock status bit. When the slot moves into the powered-off, indicator-off state while a device is present, the block requests a detach and marks the presence as changed.

The interrupt condition follows the enabled, supported events. A message pulse is emitted only when that condition rises, so an event that was pending while interrupts were disabled is delivered as soon as they are enabled.

Top module: `hp_slot_ctrl`

## Requirements
- R1: After reset the control word reads 0x00C0: attention indicator off (bits 7:6 = 11), all enables 0, power indicator 00, power controller 0. The status word reads 0 apart from presence state, and `irq_level` and `msg_pulse` are 0.
- R2: `rd_cap` is constant: the slot number sits in bits 31:19. The following present/capable bits are set: bit 17 (interlock present), bit 6 (hot-plug capable), bit 5 (surprise), bit 4 (power indicator), bit 3 (attention indicator), bit 1 (power controller) and bit 0 (attention button). With the default slot number 5 the value is 0x002A007B.
- R3: A control write (`wr_sel`=0) changes only these fields, and only in bytes whose `wr_be` bit is set: bit 0 button enable, bit 3 presence-change enable, bit 4 command-completed enable, bit 5 interrupt enable, bits 7:6 attention indicator, bits 9:8 power indicator, bit 10 power controller. Bits 1, 2 and 12 to 15 read 0.
- R4: A control write with at least one byte enable sets status bit 4 (command completed) on the following cycle. A write with `wr_be`=00 has no effect.
- R5: Control bit 11 (interlock control) always reads 0. Writing 1 to it with `wr_be[1]` set toggles status bit 7 (interlock state).
- R6: Status bits 0 to 4 (button, power fault, latch change, presence change, command completed) clear when written with 1. A hardware event in the same cycle as a clear leaves its bit set.
- R7: If a status write carries a 1 in any of bits 0 to 4 that is currently 0, bits 0 to 4 keep their previous values.
- R8: `btn_press` sets status bit 0. `dev_arrive` sets bit 6 (presence state), bit 3 (presence changed) and bit 0 (button) together.
- R9: `irq_level` is high when control bit 5 is set and the status and control words share a set bit among bits 0, 3 and 4. `msg_pulse` is high for one cycle when `irq_level` rises. Setting an already-set event raises no pulse.
- R10: An event pending while interrupts are disabled raises `irq_level` and `msg_pulse` in the cycle after the enable is written.
- R11: A control write that makes bit 10 = 1 and bits 9:8 = 11 while presence state is 1, when the previous control word was not in that state, raises `detach_req` for one cycle, clears bit 6 and sets bit 3. Repeating the same write does not raise `detach_req` again.
- R12: `pwr_on` is the inverse of control bit 10, `pwr_ind` equals bits 9:8 and `attn_ind` equals bits 7:6. The indicator encoding is 01 on, 10 blink, 11 off.
- R13: During reset, status bit 6 loads `dev_present` without setting bit 3 or raising an interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the control word, 1 selects the status word |
| wr_be | input | 2 | Byte enables, bit 0 for the low byte |
| wr_data | input | 16 | Write value |
| btn_press | input | 1 | Attention-button press pulse |
| dev_present | input | 1 | Presence level, sampled during reset |
| dev_arrive | input | 1 | Device-arrival pulse |
| rd_cap | output | 32 | Slot capability word |
| rd_ctl | output | 16 | Slot control word |
| rd_sta | output | 16 | Slot status word |
| irq_level | output | 1 | Level interrupt |
| msg_pulse | output | 1 | One-cycle interrupt message request |
| pwr_on | output | 1 | Slot power enable |
| pwr_ind | output | 2 | Power indicator state |
| attn_ind | output | 2 | Attention indicator state |
| detach_req | output | 1 | One-cycle request to detach the device |

## Verification
Every state bit in this block is visible on `rd_ctl` or `rd_sta` in the cycle after the write or event that changed it. A corrupted field therefore shows at the ports one cycle later. A wrong rollback or lost event shows as a status bit that differs from the value the bench predicts. A wrong previous-condition register shows as a missing, extra or repeated `msg_pulse`, or as a second `detach_req` after a repeated power-off write. Both are visible in the first cycle in which the condition should or should not change.

// File: rtl/hps_pkg.sv
package hps_pkg;

    localparam int WORD_W = 16;
    localparam int BYTE_N = WORD_W / 8;

    // control bit positions
    localparam int C_HPIE = 5;
    localparam int C_EIC  = 11;

    // status bit positions
    localparam int S_ABP = 0;
    localparam int S_PDC = 3;
    localparam int S_CC  = 4;
    localparam int S_PDS = 6;
    localparam int S_EIS = 7;

    localparam logic [WORD_W-1:0] CTL_WMASK = 16'h07F9;
    localparam logic [WORD_W-1:0] EVT_MASK  = 16'h001F;
    localparam logic [WORD_W-1:0] SUP_MASK  = 16'h0019;

    typedef enum logic [1:0] {
        IND_NONE  = 2'b00,
        IND_ON    = 2'b01,
        IND_BLINK = 2'b10,
        IND_OFF   = 2'b11
    } ind_e;

    typedef struct packed {
        logic [3:0] rsvd_hi;
        logic       eic;
        logic       pcc;
        ind_e       pic;
        ind_e       aic;
        logic       hpie;
        logic       cce;
        logic       pdce;
        logic [1:0] rsvd_lo;
        logic       abe;
    } slot_ctl_t;

    typedef struct packed {
        logic [7:0] rsvd_hi;
        logic       eis;
        logic       pds;
        logic       rsvd5;
        logic       cc;
        logic       pdc;
        logic       mrl;
        logic       pfd;
        logic       abp;
    } slot_sta_t;

    localparam slot_ctl_t CTL_RESET = '{aic: IND_OFF, pic: IND_NONE, default: '0};

    function automatic logic [WORD_W-1:0] byte_mask(input logic [BYTE_N-1:0] be);
        logic [WORD_W-1:0] m;
        for (int i = 0; i < BYTE_N; i++) m[i*8 +: 8] = {8{be[i]}};
        return m;
    endfunction

    function automatic logic is_off(input slot_ctl_t c);
        return c.pcc && (c.pic == IND_OFF);
    endfunction

endpackage

// File: rtl/hps_ctl_reg.sv
module hps_ctl_reg
    import hps_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_ctl,
    input  logic [BYTE_N-1:0]   be,
    input  logic [WORD_W-1:0]   data,
    input  logic                pds,
    output slot_ctl_t           ctl_q,
    output logic                cmd_done,
    output logic                eis_toggle,
    output logic                detach_fire
);
    logic [WORD_W-1:0] wm;
    logic [WORD_W-1:0] old_v;
    logic [WORD_W-1:0] new_v;
    slot_ctl_t         ctl_new;

    always_comb begin
        wm          = CTL_WMASK & byte_mask(be);
        old_v       = ctl_q;
        new_v       = (old_v & ~wm) | (data & wm);
        ctl_new     = slot_ctl_t'(new_v);
        cmd_done    = wr_ctl;
        eis_toggle  = wr_ctl && be[C_EIC/8] && data[C_EIC];
        detach_fire = wr_ctl && pds && is_off(ctl_new) && !is_off(ctl_q);
    end

    always_ff @(posedge clk) begin
        if (rst)         ctl_q <= CTL_RESET;
        else if (wr_ctl) ctl_q <= ctl_new;
    end
endmodule

// File: rtl/hps_sta_reg.sv
module hps_sta_reg
    import hps_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                dev_present,
    input  logic                wr_sta,
    input  logic [BYTE_N-1:0]   be,
    input  logic [WORD_W-1:0]   data,
    input  logic                cmd_done,
    input  logic                eis_toggle,
    input  logic                detach_fire,
    input  logic                btn,
    input  logic                arrive,
    output slot_sta_t           sta_q
);
    logic [WORD_W-1:0] cur_v;
    logic [WORD_W-1:0] clr_v;
    logic              stale;
    slot_sta_t         nxt;

    always_comb begin
        cur_v = sta_q;
        clr_v = data & byte_mask(be) & EVT_MASK;
        stale = |(clr_v & ~cur_v);
        if (wr_sta && !stale) nxt = slot_sta_t'(cur_v & ~clr_v);
        else                  nxt = sta_q;
        if (eis_toggle) nxt.eis = ~nxt.eis;
        if (detach_fire) begin
            nxt.pds = 1'b0;
            nxt.pdc = 1'b1;
        end
        if (cmd_done) nxt.cc  = 1'b1;
        if (btn)      nxt.abp = 1'b1;
        if (arrive) begin
            nxt.pds = 1'b1;
            nxt.pdc = 1'b1;
            nxt.abp = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sta_q     <= '0;
            sta_q.pds <= dev_present;
        end else begin
            sta_q <= nxt;
        end
    end
endmodule

// File: rtl/hps_irq.sv
module hps_irq
    import hps_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  slot_ctl_t ctl,
    input  slot_sta_t sta,
    output logic      irq_level,
    output logic      msg_pulse
);
    logic [WORD_W-1:0] c_v;
    logic [WORD_W-1:0] s_v;
    logic              cond;
    logic              cond_prev;

    always_comb begin
        c_v  = ctl;
        s_v  = sta;
        cond = ctl.hpie && (|(c_v & s_v & SUP_MASK));
    end

    always_ff @(posedge clk) begin
        if (rst) cond_prev <= 1'b0;
        else     cond_prev <= cond;
    end

    assign irq_level = cond;
    assign msg_pulse = cond && !cond_prev;
endmodule

// File: rtl/hp_slot_ctrl.sv
module hp_slot_ctrl
    import hps_pkg::*;
#(
    parameter int SLOT_NUM = 5,
    parameter int SLOT_W   = 13
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic        wr_sel,
    input  logic [1:0]  wr_be,
    input  logic [15:0] wr_data,
    input  logic        btn_press,
    input  logic        dev_present,
    input  logic        dev_arrive,
    output logic [31:0] rd_cap,
    output logic [15:0] rd_ctl,
    output logic [15:0] rd_sta,
    output logic        irq_level,
    output logic        msg_pulse,
    output logic        pwr_on,
    output logic [1:0]  pwr_ind,
    output logic [1:0]  attn_ind,
    output logic        detach_req
);
    localparam int          CAP_SLOT_LSB = 32 - SLOT_W;
    localparam logic [31:0] CAP_FLAGS    = 32'h0002_007B;
    localparam logic [31:0] CAP_WORD     =
        (32'(SLOT_NUM % (1 << SLOT_W)) << CAP_SLOT_LSB) | CAP_FLAGS;

    slot_ctl_t ctl_q;
    slot_sta_t sta_q;
    logic      wr_ctl, wr_sta;
    logic      cmd_done, eis_toggle, detach_fire;
    logic      detach_q;

    assign wr_ctl = wr_en && !wr_sel && (|wr_be);
    assign wr_sta = wr_en &&  wr_sel && (|wr_be);

    hps_ctl_reg u_ctl (
        .clk(clk), .rst(rst), .wr_ctl(wr_ctl), .be(wr_be), .data(wr_data),
        .pds(sta_q.pds), .ctl_q(ctl_q), .cmd_done(cmd_done),
        .eis_toggle(eis_toggle), .detach_fire(detach_fire)
    );

    hps_sta_reg u_sta (
        .clk(clk), .rst(rst), .dev_present(dev_present), .wr_sta(wr_sta),
        .be(wr_be), .data(wr_data), .cmd_done(cmd_done),
        .eis_toggle(eis_toggle), .detach_fire(detach_fire),
        .btn(btn_press), .arrive(dev_arrive), .sta_q(sta_q)
    );

    hps_irq u_irq (
        .clk(clk), .rst(rst), .ctl(ctl_q), .sta(sta_q),
        .irq_level(irq_level), .msg_pulse(msg_pulse)
    );

    always_ff @(posedge clk) begin
        if (rst) detach_q <= 1'b0;
        else     detach_q <= detach_fire;
    end

    assign rd_cap     = CAP_WORD;
    assign rd_ctl     = ctl_q;
    assign rd_sta     = sta_q;
    assign pwr_on     = !ctl_q.pcc;
    assign pwr_ind    = ctl_q.pic;
    assign attn_ind   = ctl_q.aic;
    assign detach_req = detach_q;
endmodule

// File: rtl/hps_chk.sv
module hps_chk (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic        wr_sel,
    input logic [1:0]  wr_be,
    input logic [15:0] wr_data,
    input logic        btn_press,
    input logic        dev_arrive,
    input logic [15:0] rd_sta,
    input logic        irq_level,
    input logic        msg_pulse,
    input logic        detach_req
);
    logic [15:0] wr_bytes;
    logic        stale_clear;
    assign wr_bytes    = wr_data & {{8{wr_be[1]}}, {8{wr_be[0]}}};
    assign stale_clear = |(wr_bytes & ~rd_sta & 16'h001F);

    assert_cmd_done_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_sel && (wr_be != 2'b00)) |=> rd_sta[4]);

    assert_interlock_toggle_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_sel && wr_be[1] && wr_data[11]) |=> (rd_sta[7] != $past(rd_sta[7])));

    assert_rollback_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel && stale_clear && !btn_press && !dev_arrive) |=> $stable(rd_sta[4:0]));

    assert_arrival_R8: assert property (@(posedge clk) disable iff (rst)
        dev_arrive |=> (rd_sta[6] && rd_sta[3] && rd_sta[0]));

    assert_msg_edge_R9: assert property (@(posedge clk) disable iff (rst)
        msg_pulse |-> (irq_level && !$past(irq_level)));

    assert_detach_R11: assert property (@(posedge clk) disable iff (rst)
        (detach_req && !$past(dev_arrive)) |-> (!rd_sta[6] && rd_sta[3]));
endmodule

bind hp_slot_ctrl hps_chk u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_be(wr_be),
    .wr_data(wr_data), .btn_press(btn_press), .dev_arrive(dev_arrive),
    .rd_sta(rd_sta), .irq_level(irq_level), .msg_pulse(msg_pulse),
    .detach_req(detach_req)
);

// File: tb/hp_slot_ctrl_tb.sv
`timescale 1ns/1ps
module hp_slot_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, wr_sel = 1'b0;
    logic [1:0]  wr_be = 2'b00;
    logic [15:0] wr_data = 16'h0;
    logic        btn_press = 1'b0, dev_present = 1'b0, dev_arrive = 1'b0;
    logic [31:0] rd_cap;
    logic [15:0] rd_ctl, rd_sta;
    logic        irq_level, msg_pulse, pwr_on, detach_req;
    logic [1:0]  pwr_ind, attn_ind;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    hp_slot_ctrl u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_be(wr_be),
        .wr_data(wr_data), .btn_press(btn_press), .dev_present(dev_present),
        .dev_arrive(dev_arrive), .rd_cap(rd_cap), .rd_ctl(rd_ctl),
        .rd_sta(rd_sta), .irq_level(irq_level), .msg_pulse(msg_pulse),
        .pwr_on(pwr_on), .pwr_ind(pwr_ind), .attn_ind(attn_ind),
        .detach_req(detach_req)
    );

    // {kind, be, data, exp_ctl, exp_sta, exp_irq, exp_msg, exp_det, req}
    // kind: 0 control write, 1 status write, 2 button, 3 arrival
    localparam int NV = 14;
    localparam logic [58:0] VEC [NV] = '{
        {2'd2, 2'b00, 16'h0000, 16'h00C0, 16'h0001, 1'b0, 1'b0, 1'b0, 4'd8},  // R8 button
        {2'd0, 2'b11, 16'h0039, 16'h0039, 16'h0011, 1'b1, 1'b1, 1'b0, 4'd4},  // R4 R9 enable
        {2'd1, 2'b11, 16'h0011, 16'h0039, 16'h0000, 1'b0, 1'b0, 1'b0, 4'd6},  // R6 clear
        {2'd2, 2'b00, 16'h0000, 16'h0039, 16'h0001, 1'b1, 1'b1, 1'b0, 4'd9},  // R9 rise
        {2'd1, 2'b11, 16'h0003, 16'h0039, 16'h0001, 1'b1, 1'b0, 1'b0, 4'd7},  // R7 rollback
        {2'd1, 2'b11, 16'h0001, 16'h0039, 16'h0000, 1'b0, 1'b0, 1'b0, 4'd6},  // R6
        {2'd0, 2'b01, 16'hFFFF, 16'h00F9, 16'h0010, 1'b1, 1'b1, 1'b0, 4'd3},  // R3 low byte
        {2'd0, 2'b10, 16'h0D00, 16'h05F9, 16'h0090, 1'b1, 1'b0, 1'b0, 4'd5},  // R5 toggle, R9 no re-pulse
        {2'd0, 2'b00, 16'hFFFF, 16'h05F9, 16'h0090, 1'b1, 1'b0, 1'b0, 4'd4},  // R4 no enables
        {2'd1, 2'b11, 16'h0010, 16'h05F9, 16'h0080, 1'b0, 1'b0, 1'b0, 4'd6},  // R6
        {2'd3, 2'b00, 16'h0000, 16'h05F9, 16'h00C9, 1'b1, 1'b1, 1'b0, 4'd8},  // R8 arrival
        {2'd1, 2'b11, 16'h0009, 16'h05F9, 16'h00C0, 1'b0, 1'b0, 1'b0, 4'd6},  // R6
        {2'd0, 2'b11, 16'h07F9, 16'h07F9, 16'h0098, 1'b1, 1'b1, 1'b1, 4'd11}, // R11 detach
        {2'd0, 2'b11, 16'h07F9, 16'h07F9, 16'h0098, 1'b1, 1'b0, 1'b0, 4'd11}  // R11 no repeat
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [1:0] kind, input logic [1:0] be, input logic [15:0] d,
                         input logic also_btn);
        @(negedge clk);
        wr_en      = (kind < 2'd2);
        wr_sel     = (kind == 2'd1);
        wr_be      = be;
        wr_data    = d;
        btn_press  = (kind == 2'd2) || also_btn;
        dev_arrive = (kind == 2'd3);
        @(negedge clk);
        wr_en = 1'b0; wr_be = 2'b00; btn_press = 1'b0; dev_arrive = 1'b0;
    endtask

    task automatic do_reset(input logic present);
        @(negedge clk);
        rst = 1'b1;
        dev_present = present;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        // R1 R2 R12: reset state
        do_reset(1'b0);
        check("R1 ctl", {16'h0, rd_ctl}, 32'h00C0);
        check("R1 sta", {16'h0, rd_sta}, 32'h0000);
        check("R1 irq/msg", {30'h0, irq_level, msg_pulse}, 32'h0);
        check("R2 cap", rd_cap, 32'h002A007B);
        check("R12 reset outputs", {27'h0, pwr_on, pwr_ind, attn_ind}, {27'h0, 1'b1, 2'b00, 2'b11});

        for (int i = 0; i < NV; i++) begin
            logic [58:0] v;
            v = VEC[i];
            apply(v[58:57], v[56:55], v[54:39], 1'b0);
            total++;
            if ({rd_ctl, rd_sta, irq_level, msg_pulse, detach_req} !== v[38:4]) begin
                fails++;
                $display("FAIL vec %0d R%0d actual=%h/%h/%b%b%b expected=%h/%h/%b%b%b",
                         i, v[3:0], rd_ctl, rd_sta, irq_level, msg_pulse, detach_req,
                         v[38:23], v[22:7], v[6], v[5], v[4]);
            end
        end

        // R12 outputs after the power-off write
        check("R12 outputs", {27'h0, pwr_on, pwr_ind, attn_ind}, {27'h0, 1'b0, 2'b11, 2'b11});

        // R13 presence loaded at reset
        do_reset(1'b1);
        check("R13 sta", {16'h0, rd_sta}, 32'h0040);
        check("R13 irq", {31'h0, irq_level}, 32'h0);

        // R3 reserved and interlock bits read zero
        do_reset(1'b0);
        apply(2'd0, 2'b11, 16'hF006, 1'b0);
        check("R3 reserved", {16'h0, rd_ctl}, 32'h0000);
        check("R3 sta", {16'h0, rd_sta}, 32'h0010);

        // R10 deferred delivery
        do_reset(1'b0);
        apply(2'd0, 2'b11, 16'h0001, 1'b0);
        apply(2'd2, 2'b00, 16'h0000, 1'b0);
        check("R10 masked", {30'h0, irq_level, msg_pulse}, 32'h0);
        check("R10 pending sta", {16'h0, rd_sta}, 32'h0011);
        apply(2'd0, 2'b11, 16'h0021, 1'b0);
        check("R10 delivered", {30'h0, irq_level, msg_pulse}, 32'h3);

        // R6 clear racing a new button press
        do_reset(1'b0);
        apply(2'd2, 2'b00, 16'h0000, 1'b0);
        apply(2'd1, 2'b11, 16'h0001, 1'b1);
        check("R6 race", {16'h0, rd_sta}, 32'h0001);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule